// File: doc/BRIEF.md
# Floating-point conditional select unit

This unit accepts one 32-bit instruction word per cycle together with a valid strobe and the four arithmetic flags. It recognises the floating-point conditional-select encoding by its fixed opcode bits. From the word it pulls a two-bit condition selector, a precision field and three split register indices. It looks up both source operands in an external register file through two combinational read ports. The first source is chosen when the condition holds on the flags, and the second source otherwise. One cycle later the unit issues a single write to the destination register.

The register file holds 32 single-precision words. A double-precision register `k` is the pair of singles `2k` (low half) and `2k+1` (high half). Half-precision results land in a single register, zero-extended from 16 bits. Encodings the unit cannot execute raise a one-cycle undefined pulse instead of writing. These are the reserved size, half precision with FP16 support strapped off, and a double index of 16 or above. A parameter selects how the unit treats an instruction issued inside a conditional (IT) block. It can flag the instruction as undefined, execute it as if the condition passed, or drop it silently.

Top module: `fp_cond_select`

## Requirements
- R1: A word is accepted only when bits 31:23 are `111111100`, bits 11:10 are `10`, bit 6 is 0 and bit 4 is 0. Any other word produces neither a write nor an undefined pulse.
- R2: The selector in bits 21:20 picks the condition. `00` holds when Z=1, `01` when V=1, `10` when N equals V, and `11` when Z=0 and N equals V. The flag input is ordered N=bit 3, Z=bit 2, C=bit 1, V=bit 0. When the condition holds, the source named by bits 19:16 and bit 7 is written; otherwise the source named by bits 3:0 and bit 5 is written.
- R3: The extra index bits are bit 22 for the destination, bit 7 for the first source and bit 5 for the second source. For half and single precision each index is {4-bit field, extra bit}, with the extra bit as the LSB. For double precision each index is {extra bit, 4-bit field}, and the read and write addresses are given in single units as twice the double index.
- R4: Size `01` (half) writes the low 16 bits of the selected operand with bits 63:16 of the write data zero, and `wrDouble` low.
- R5: Size `10` (single) writes all 32 bits of the selected single with bits 63:32 zero, and `wrDouble` low.
- R6: Size `11` (double) writes all 64 bits of the selected register pair with `wrDouble` high, at an even single address.
- R7: Size `00`, size `01` with `fp16En` low, and a double-precision word with any extra index bit set each raise `undefOut` and cause no write.
- R8: With `inCondBlock` high, policy 0 raises `undefOut` without writing. Policy 1 writes the first source regardless of the flags. Policy 2 writes nothing and raises no undefined pulse unless R7 applies.
- R9: Results and undefined pulses appear exactly one cycle after the accepted valid strobe, whatever the operand data or flag values. No output appears in a cycle that follows a cycle without `instrValid`.
- R10: While `rstN` is low, `wrEn` and `undefOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| instrValid | input | 1 | Instruction word is valid this cycle |
| nzcv | input | 4 | Flags N, Z, C, V (bit 3 down to bit 0) |
| fp16En | input | 1 | Half-precision support strap |
| inCondBlock | input | 1 | Instruction is inside a conditional (IT) block |
| rdAddrN | output | 5 | Single index of the first source (low word for doubles) |
| rdDataN | input | 64 | First source: upper word from index+1, lower word from index |
| rdAddrM | output | 5 | Single index of the second source |
| rdDataM | input | 64 | Second source, same layout as rdDataN |
| wrEn | output | 1 | Register-file write strobe |
| wrDouble | output | 1 | Write covers two singles (wrAddr and wrAddr+1) |
| wrAddr | output | 5 | Single index of the destination |
| wrData | output | 64 | Write data; upper word used only when wrDouble is high |
| undefOut | output | 1 | Undefined-instruction pulse |

## Verification
The bench sweeps every selector against every precision and all sixteen flag patterns. A wrong condition table or an inverted operand choice shows up there as data from the wrong register. Source pairs always differ, and the singles carry non-zero upper halves. A design that swaps the extra index bit between the narrow and wide layouts therefore writes to the wrong address, and one that skips zero-extension leaks the upper half into a half-precision result. Each single opcode bit is flipped, each extra index bit is set in double mode, and the reserved size and FP16 strap are exercised; a sloppy decoder would write or flag where it must stay silent. Three instances, one per conditional-block policy, receive the same word with a failing condition. A policy swapped for another one gives the wrong write or pulse.

// File: rtl/fcsel_pkg.sv
package fcsel_pkg;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned FIELD_W   = 4;
  localparam int unsigned REG_IDX_W = FIELD_W + 1;
  localparam int unsigned NUM_OPND  = 3;

  localparam logic [8:0] OPC_HIGH = 9'b111111100;
  localparam logic [1:0] OPC_MID  = 2'b10;

  // conditional-block policies
  localparam int unsigned ITP_UNDEF = 0;
  localparam int unsigned ITP_FORCE = 1;
  localparam int unsigned ITP_NOP   = 2;

  typedef enum logic [1:0] {
    PREC_NONE   = 2'b00,
    PREC_HALF   = 2'b01,
    PREC_SINGLE = 2'b10,
    PREC_DOUBLE = 2'b11
  } prec_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                 commit;
    logic                 undef;
    logic                 takeFirst;
    prec_e                prec;
    logic [REG_IDX_W-1:0] dstAddr;
  } ctrlStrobe_t;

endpackage

// File: rtl/fcsel_cond.sv
module fcsel_cond (
  input  logic [3:0] condCode,
  input  logic [3:0] nzcv,
  output logic       holds
);
  logic flagN, flagZ, flagC, flagV;
  logic base;

  assign {flagN, flagZ, flagC, flagV} = nzcv;

  // generic 4-bit condition: upper three bits pick a test, LSB inverts it
  always_comb begin
    unique case (condCode[3:1])
      3'd0:    base = flagZ;
      3'd1:    base = flagC;
      3'd2:    base = flagN;
      3'd3:    base = flagV;
      3'd4:    base = flagC & ~flagZ;
      3'd5:    base = (flagN == flagV);
      3'd6:    base = ~flagZ & (flagN == flagV);
      default: base = 1'b1;
    endcase
    holds = (condCode[3:1] == 3'b111) ? 1'b1 : (base ^ condCode[0]);
  end
endmodule

// File: rtl/fcsel_ctrl.sv
module fcsel_ctrl
  import fcsel_pkg::*;
#(
  parameter int unsigned IT_POLICY = ITP_UNDEF
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 instrValid,
  input  logic [3:0]           nzcv,
  input  logic                 fp16En,
  input  logic                 inCondBlock,
  output logic [REG_IDX_W-1:0] rdAddrN,
  output logic [REG_IDX_W-1:0] rdAddrM,
  output ctrlStrobe_t          strobe
);
  logic        opMatch;
  prec_e       prec;
  logic        isDouble;
  logic [1:0]  selCode;
  logic [3:0]  condCode;
  logic        condHolds;
  logic        sizeBad;
  logic        bankBad;
  logic        itUndef, itForce, itSkip;
  logic        decodeUndef;

  logic [FIELD_W-1:0]   regField [NUM_OPND];
  logic                 regExtra [NUM_OPND];
  logic [REG_IDX_W-1:0] wordAddr [NUM_OPND];
  logic [NUM_OPND-1:0]  highBank;

  assign opMatch = (instr[31:23] == OPC_HIGH) && (instr[11:10] == OPC_MID)
                && !instr[6] && !instr[4];

  assign prec     = prec_e'(instr[9:8]);
  assign isDouble = (prec == PREC_DOUBLE);

  // operand 0: destination, 1: first source, 2: second source
  assign regField[0] = instr[15:12];
  assign regExtra[0] = instr[22];
  assign regField[1] = instr[19:16];
  assign regExtra[1] = instr[7];
  assign regField[2] = instr[3:0];
  assign regExtra[2] = instr[5];

  generate
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_index
      // narrow: extra bit is LSB; wide: extra bit is MSB of the pair index,
      // pair k lives at single 2k
      assign wordAddr[g] = isDouble ? {regField[g], 1'b0}
                                    : {regField[g], regExtra[g]};
      assign highBank[g] = isDouble & regExtra[g];
    end
  endgenerate

  // 2-bit selector widened to the 4-bit condition space
  assign selCode  = instr[21:20];
  assign condCode = {selCode, selCode[1] ^ selCode[0], 1'b0};

  fcsel_cond u_cond (
    .condCode (condCode),
    .nzcv     (nzcv),
    .holds    (condHolds)
  );

  generate
    if (IT_POLICY == ITP_FORCE) begin : g_itForce
      assign itUndef = 1'b0;
      assign itForce = inCondBlock;
      assign itSkip  = 1'b0;
    end else if (IT_POLICY == ITP_NOP) begin : g_itNop
      assign itUndef = 1'b0;
      assign itForce = 1'b0;
      assign itSkip  = inCondBlock;
    end else begin : g_itUndef
      assign itUndef = inCondBlock;
      assign itForce = 1'b0;
      assign itSkip  = 1'b0;
    end
  endgenerate

  assign sizeBad     = (prec == PREC_NONE) || ((prec == PREC_HALF) && !fp16En);
  assign bankBad     = |highBank;
  assign decodeUndef = sizeBad || bankBad || itUndef;

  assign rdAddrN = wordAddr[1];
  assign rdAddrM = wordAddr[2];

  always_comb begin
    strobe.commit    = instrValid && opMatch && !decodeUndef && !itSkip;
    strobe.undef     = instrValid && opMatch && decodeUndef;
    strobe.takeFirst = condHolds || itForce;
    strobe.prec      = prec;
    strobe.dstAddr   = wordAddr[0];
  end
endmodule

// File: rtl/fcsel_dpath.sv
module fcsel_dpath
  import fcsel_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [2*WORD_W-1:0]  rdDataN,
  input  logic [2*WORD_W-1:0]  rdDataM,
  output logic                 wrEn,
  output logic                 wrDouble,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [2*WORD_W-1:0]  wrData,
  output logic                 undefOut
);
  localparam int unsigned DW     = 2 * WORD_W;
  localparam int unsigned HALF_W = WORD_W / 2;

  logic [DW-1:0] picked;
  logic [DW-1:0] shaped;

  // operand choice is a plain mux: no data-dependent timing
  assign picked = strobe.takeFirst ? rdDataN : rdDataM;

  always_comb begin
    unique case (strobe.prec)
      PREC_HALF:   shaped = {{(DW-HALF_W){1'b0}}, picked[HALF_W-1:0]};
      PREC_SINGLE: shaped = {{(DW-WORD_W){1'b0}}, picked[WORD_W-1:0]};
      default:     shaped = picked;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      wrDouble <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      undefOut <= 1'b0;
    end else begin
      wrEn     <= strobe.commit;
      wrDouble <= strobe.commit && (strobe.prec == PREC_DOUBLE);
      wrAddr   <= strobe.commit ? strobe.dstAddr : '0;
      wrData   <= strobe.commit ? shaped : '0;
      undefOut <= strobe.undef;
    end
  end
endmodule

// File: rtl/fp_cond_select.sv
module fp_cond_select
  import fcsel_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IT_POLICY = ITP_UNDEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 instrValid,
  input  logic [3:0]           nzcv,
  input  logic                 fp16En,
  input  logic                 inCondBlock,
  output logic [REG_IDX_W-1:0] rdAddrN,
  input  logic [2*WORD_W-1:0]  rdDataN,
  output logic [REG_IDX_W-1:0] rdAddrM,
  input  logic [2*WORD_W-1:0]  rdDataM,
  output logic                 wrEn,
  output logic                 wrDouble,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [2*WORD_W-1:0]  wrData,
  output logic                 undefOut
);
  ctrlStrobe_t strobe;

  fcsel_ctrl #(.IT_POLICY(IT_POLICY)) u_ctrl (
    .instr       (instr),
    .instrValid  (instrValid),
    .nzcv        (nzcv),
    .fp16En      (fp16En),
    .inCondBlock (inCondBlock),
    .rdAddrN     (rdAddrN),
    .rdAddrM     (rdAddrM),
    .strobe      (strobe)
  );

  fcsel_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdDataN  (rdDataN),
    .rdDataM  (rdDataM),
    .wrEn     (wrEn),
    .wrDouble (wrDouble),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .undefOut (undefOut)
  );
endmodule

// File: rtl/fp_cond_select_chk.sv
module fp_cond_select_chk
  import fcsel_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IT_POLICY = ITP_UNDEF
) (
  input logic                clk,
  input logic                rstN,
  input logic [8:0]          opHigh,
  input logic [1:0]          sizeField,
  input logic                instrValid,
  input logic                inCondBlock,
  input logic                rdAddrNLsb,
  input logic                rdAddrMLsb,
  input logic                wrEn,
  input logic                wrDouble,
  input logic                wrAddrLsb,
  input logic [2*WORD_W-1:0] wrData,
  input logic                undefOut
);
  localparam int unsigned DW     = 2 * WORD_W;
  localparam int unsigned HALF_W = WORD_W / 2;

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || undefOut) |-> $past(instrValid));

  assert_undef_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    undefOut |-> !wrEn);

  assert_opcode_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && opHigh != OPC_HIGH) |=> (!wrEn && !undefOut));

  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrDouble) |-> (wrData[DW-1:WORD_W] == '0));

  assert_half_zero_ext_R4: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && sizeField == 2'b01) |=> (!wrEn || (wrData[DW-1:HALF_W] == '0)));

  assert_double_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrDouble |-> (wrEn && !wrAddrLsb));

  assert_double_read_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && sizeField == 2'b11) |-> (!rdAddrNLsb && !rdAddrMLsb));

  assert_block_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (IT_POLICY != ITP_FORCE && instrValid && inCondBlock) |=> !wrEn);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |-> (!wrEn && !undefOut));
endmodule

bind fp_cond_select fp_cond_select_chk #(.WORD_W(WORD_W), .IT_POLICY(IT_POLICY)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opHigh      (instr[31:23]),
  .sizeField   (instr[9:8]),
  .instrValid  (instrValid),
  .inCondBlock (inCondBlock),
  .rdAddrNLsb  (rdAddrN[0]),
  .rdAddrMLsb  (rdAddrM[0]),
  .wrEn        (wrEn),
  .wrDouble    (wrDouble),
  .wrAddrLsb   (wrAddr[0]),
  .wrData      (wrData),
  .undefOut    (undefOut)
);

// File: tb/fp_cond_select_tb.sv
module fp_cond_select_tb;

  typedef struct packed {
    logic [127:0] tag;
    logic         wr;
    logic         undef;
    logic         dbl;
    logic [4:0]   addr;
    logic [63:0]  data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] instr;
  logic        instrValid;
  logic [3:0]  nzcv;
  logic        fp16En;
  logic        inCondBlock;

  logic [4:0]  rdAddrN [3];
  logic [4:0]  rdAddrM [3];
  logic [63:0] rdDataN [3];
  logic [63:0] rdDataM [3];
  logic        wrEn [3];
  logic        wrDouble [3];
  logic [4:0]  wrAddr [3];
  logic [63:0] wrData [3];
  logic        undefOut [3];

  logic [31:0] rf [32];

  int   checks = 0;
  int   fails  = 0;
  logic done   = 1'b0;
  exp_t q0[$];
  exp_t q1[$];
  exp_t q2[$];
  exp_t e0, e1, e2;

  always #2ns clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_rf
    assign rdDataN[p] = {rf[rdAddrN[p] + 5'd1], rf[rdAddrN[p]]};
    assign rdDataM[p] = {rf[rdAddrM[p] + 5'd1], rf[rdAddrM[p]]};
  end

  fp_cond_select #(.IT_POLICY(0)) u_dut (
    .clk(clk), .rstN(rstN), .instr(instr), .instrValid(instrValid), .nzcv(nzcv),
    .fp16En(fp16En), .inCondBlock(inCondBlock),
    .rdAddrN(rdAddrN[0]), .rdDataN(rdDataN[0]), .rdAddrM(rdAddrM[0]), .rdDataM(rdDataM[0]),
    .wrEn(wrEn[0]), .wrDouble(wrDouble[0]), .wrAddr(wrAddr[0]), .wrData(wrData[0]),
    .undefOut(undefOut[0]));

  fp_cond_select #(.IT_POLICY(1)) u_dutForce (
    .clk(clk), .rstN(rstN), .instr(instr), .instrValid(instrValid), .nzcv(nzcv),
    .fp16En(fp16En), .inCondBlock(inCondBlock),
    .rdAddrN(rdAddrN[1]), .rdDataN(rdDataN[1]), .rdAddrM(rdAddrM[1]), .rdDataM(rdDataM[1]),
    .wrEn(wrEn[1]), .wrDouble(wrDouble[1]), .wrAddr(wrAddr[1]), .wrData(wrData[1]),
    .undefOut(undefOut[1]));

  fp_cond_select #(.IT_POLICY(2)) u_dutNop (
    .clk(clk), .rstN(rstN), .instr(instr), .instrValid(instrValid), .nzcv(nzcv),
    .fp16En(fp16En), .inCondBlock(inCondBlock),
    .rdAddrN(rdAddrN[2]), .rdDataN(rdDataN[2]), .rdAddrM(rdAddrM[2]), .rdDataM(rdDataM[2]),
    .wrEn(wrEn[2]), .wrDouble(wrDouble[2]), .wrAddr(wrAddr[2]), .wrData(wrData[2]),
    .undefOut(undefOut[2]));

  // build an instruction word from logical indices (R1, R3 layout)
  function automatic logic [31:0] mk(logic [1:0] sel, logic [1:0] sz, int d, int n, int m);
    logic [4:0] dd, nn, mm;
    dd = d[4:0]; nn = n[4:0]; mm = m[4:0];
    if (sz == 2'b11)
      return {9'b111111100, dd[4], sel, nn[3:0], dd[3:0], 2'b10, sz,
              nn[4], 1'b0, mm[4], 1'b0, mm[3:0]};
    else
      return {9'b111111100, dd[0], sel, nn[4:1], dd[4:1], 2'b10, sz,
              nn[0], 1'b0, mm[0], 1'b0, mm[4:1]};
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(int pol, logic [31:0] ins, logic [3:0] fl, logic fp, logic it);
    exp_t e;
    logic match, bad, ok, fN, fZ, fV;
    logic [1:0] sz;
    int d, n, m, src;
    logic [63:0] val;
    match = (ins[31:23] == 9'b111111100) && (ins[11:10] == 2'b10) && !ins[6] && !ins[4];
    sz = ins[9:8];
    if (sz == 2'b11) begin
      d = int'({ins[22], ins[15:12]}); n = int'({ins[7], ins[19:16]}); m = int'({ins[5], ins[3:0]});
    end else begin
      d = int'({ins[15:12], ins[22]}); n = int'({ins[19:16], ins[7]}); m = int'({ins[3:0], ins[5]});
    end
    bad = (sz == 2'b00) || (sz == 2'b01 && !fp) ||
          (sz == 2'b11 && (d >= 16 || n >= 16 || m >= 16)) || (it && pol == 0);
    fN = fl[3]; fZ = fl[2]; fV = fl[0];
    case (ins[21:20])
      2'b00:   ok = fZ;
      2'b01:   ok = fV;
      2'b10:   ok = (fN == fV);
      default: ok = !fZ && (fN == fV);
    endcase
    if (it && pol == 1) ok = 1'b1;
    src = ok ? n : m;
    val = '0;
    e = '0;
    e.wr    = match && !bad && !(it && pol == 2);
    e.undef = match && bad;
    if (e.wr) begin
      if (sz == 2'b11) begin
        val = {rf[2*src+1], rf[2*src]};
        e.addr = 5'(2*d);
        e.dbl  = 1'b1;
      end else begin
        val = (sz == 2'b10) ? {32'h0, rf[src]} : {48'h0, rf[src][15:0]};
        e.addr = 5'(d);
      end
    end
    e.data = val;
    return e;
  endfunction

  task automatic checkOne(string who, exp_t e, logic we, logic ud, logic db,
                          logic [4:0] ad, logic [63:0] dt);
    checks++;
    if (we !== e.wr || ud !== e.undef ||
        (e.wr && (db !== e.dbl || ad !== e.addr || dt !== e.data))) begin
      fails++;
      $display("FAIL [%0s] %0s: got wr=%0b undef=%0b dbl=%0b addr=%0d data=%h, expected wr=%0b undef=%0b dbl=%0b addr=%0d data=%h",
               e.tag, who, we, ud, db, ad, dt, e.wr, e.undef, e.dbl, e.addr, e.data);
    end
  endtask

  task automatic checkIdle(int p, string tag);
    checks++;
    if (wrEn[p] !== 1'b0 || undefOut[p] !== 1'b0) begin
      fails++;
      $display("FAIL [%0s] instance %0d: got wrEn=%0b undef=%0b, expected wrEn=0 undef=0",
               tag, p, wrEn[p], undefOut[p]);
    end
  endtask

  // driver: one word per call, held valid until the next call or idle()
  task automatic send(logic [31:0] ins, logic [3:0] fl, logic fp, logic it, logic [127:0] tag);
    exp_t e;
    @(negedge clk);
    instr = ins; nzcv = fl; fp16En = fp; inCondBlock = it; instrValid = 1'b1;
    e = model(0, ins, fl, fp, it); e.tag = tag; q0.push_back(e);
    e = model(1, ins, fl, fp, it); e.tag = tag; q1.push_back(e);
    e = model(2, ins, fl, fp, it); e.tag = tag; q2.push_back(e);
  endtask

  // R9: a valid-looking word with the strobe low must leave no trace
  task automatic idle();
    @(negedge clk);
    instrValid = 1'b0;
    instr = mk(2'b00, 2'b10, 3, 4, 5);
    nzcv = 4'b0100;
  endtask

  // monitor: one expected item per cycle, sampled after the edge
  always @(posedge clk) begin
    #1ns;
    if (rstN && !done) begin
      if (q0.size() > 0) begin
        e0 = q0.pop_front(); e1 = q1.pop_front(); e2 = q2.pop_front();
        checkOne("policy undef", e0, wrEn[0], undefOut[0], wrDouble[0], wrAddr[0], wrData[0]);
        checkOne("policy force", e1, wrEn[1], undefOut[1], wrDouble[1], wrAddr[1], wrData[1]);
        checkOne("policy nop",   e2, wrEn[2], undefOut[2], wrDouble[2], wrAddr[2], wrData[2]);
      end else begin
        for (int p = 0; p < 3; p++) checkIdle(p, "R9 idle");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL [watchdog] run did not finish: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k, d, n, m;
    logic [127:0] tag;
    for (int i = 0; i < 32; i++) rf[i] = 32'hC0DE0000 + i * 32'h01010111;
    rstN = 1'b0; instrValid = 1'b0; instr = '0; nzcv = '0; fp16En = 1'b1; inCondBlock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 3; p++) checkIdle(p, "R10 reset");
    rstN = 1'b1;

    // R2..R6 sweep: every selector x precision x flag pattern
    for (int s = 0; s < 4; s++) begin
      for (int z = 1; z < 4; z++) begin
        for (int f = 0; f < 16; f++) begin
          k = s * 48 + (z - 1) * 16 + f;
          if (z == 3) begin
            d = k % 16; n = (k * 5 + 1) % 16; m = (n + 1 + k % 14) % 16;
            tag = "R2 R3 R6 sweep";
          end else begin
            d = k % 32; n = (k * 7 + 3) % 32; m = (n + 1 + k % 30) % 32;
            tag = (z == 1) ? "R2 R3 R4 sweep" : "R2 R3 R5 sweep";
          end
          send(mk(2'(s), 2'(z), d, n, m), 4'(f), 1'b1, 1'b0, tag);
          if (k % 5 == 4) idle();
        end
      end
    end
    idle();

    // R3 edge indices
    send(mk(2'b00, 2'b10, 31, 0, 31), 4'b0100, 1'b1, 1'b0, "R3 single 31/0");
    send(mk(2'b00, 2'b10, 0, 31, 1),  4'b0000, 1'b1, 1'b0, "R3 single 0/31");
    send(mk(2'b11, 2'b11, 15, 0, 15), 4'b0000, 1'b1, 1'b0, "R3 R6 double 15");
    send(mk(2'b11, 2'b01, 17, 30, 1), 4'b1001, 1'b1, 1'b0, "R3 R4 half odd");

    // R1 opcode mismatches, one bit at a time
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h8000_0000, 4'b0100, 1'b1, 1'b0, "R1 bit31");
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h0080_0000, 4'b0100, 1'b1, 1'b0, "R1 bit23");
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h0000_0800, 4'b0100, 1'b1, 1'b0, "R1 bit11");
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h0000_0400, 4'b0100, 1'b1, 1'b0, "R1 bit10");
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h0000_0040, 4'b0100, 1'b1, 1'b0, "R1 bit6");
    send(mk(2'b00, 2'b10, 1, 2, 3) ^ 32'h0000_0010, 4'b0100, 1'b1, 1'b0, "R1 bit4");
    send(mk(2'b00, 2'b00, 1, 2, 3) ^ 32'h0000_0010, 4'b0100, 1'b1, 1'b0, "R1 R7 both");

    // R7 undefined encodings
    send(mk(2'b00, 2'b00, 1, 2, 3),   4'b0100, 1'b1, 1'b0, "R7 size 00");
    send(mk(2'b01, 2'b01, 4, 5, 6),   4'b0001, 1'b0, 1'b0, "R7 half no fp16");
    send(mk(2'b01, 2'b10, 4, 5, 6),   4'b0001, 1'b0, 1'b0, "R5 R7 single ok");
    send(mk(2'b10, 2'b11, 16, 2, 3),  4'b0000, 1'b1, 1'b0, "R7 dbl D hi");
    send(mk(2'b10, 2'b11, 1, 18, 3),  4'b0000, 1'b1, 1'b0, "R7 dbl N hi");
    send(mk(2'b10, 2'b11, 1, 2, 31),  4'b0000, 1'b1, 1'b0, "R7 dbl M hi");
    idle();

    // R8 conditional-block policies, failing and passing conditions
    send(mk(2'b00, 2'b10, 7, 8, 9),   4'b0000, 1'b1, 1'b1, "R8 single fail");
    send(mk(2'b00, 2'b10, 7, 8, 9),   4'b0100, 1'b1, 1'b1, "R8 single pass");
    send(mk(2'b11, 2'b11, 3, 4, 5),   4'b0100, 1'b1, 1'b1, "R8 R6 dbl fail");
    send(mk(2'b01, 2'b01, 10, 11, 12),4'b0000, 1'b1, 1'b1, "R8 R4 half fail");
    send(mk(2'b00, 2'b00, 7, 8, 9),   4'b0000, 1'b1, 1'b1, "R8 R7 bad size");
    idle();
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule